// File: doc/BRIEF.md
# Coefficient-Partitioned Overlap-Add Complex FIR

This block is a time-domain complex FIR filter that takes fixed-point samples. The full tap set is cut into equal, contiguous groups of taps. Each group drives its own short sub-filter, and each sub-filter sees the entire input stream. The partial result of group g is then delayed by g times the group length and added to the other partial results. Because the delayed partials overlap and are added together, the sum is exactly the full-length convolution.

Taps are written through a simple write port into a small register file while the block is idle. A stream is started by the first accepted sample on a valid/ready input. One output is produced for each accepted sample. When the caller pulses flush, the block feeds in enough zero samples to drain the tail of the convolution, emits the remaining outputs, and raises a one-cycle done pulse. It then returns to idle with its history cleared, ready for the next stream.

Top module: `ola_fir`

## Requirements
- R1: A tap write (`cfg_we` high, `cfg_addr` = tap index k, 0 = the tap applied to the newest sample) while the block is idle stores the complex tap h[k] used by all later streams.
- R2: A tap write while a stream is in progress (from the first accepted sample until done) is ignored and does not change any output of that stream or of later streams.
- R3: Output n equals the sum over k = 0..15 of x[n-k]·h[k]. Inputs before the first sample of the stream are zero. The complex product is (a·c − b·d) + i(a·d + b·c).
- R4: Each sample accepted at a clock edge produces `out_valid` high during the third cycle after that edge's cycle: two cycles low, then high. Outputs come out in input order, with any gaps between inputs allowed.
- R5: A flush pulse during a stream appends exactly 15 tail outputs, so a stream of n inputs yields n + 15 outputs.
- R6: `done` is high for exactly one cycle. That cycle immediately follows the last output of the stream. The next stream starts from an all-zero history.
- R7: Each output part is the 36-bit accumulated sum, arithmetically shifted right by 15, then saturated to the range [−32768, 32767].
- R8: After reset, `out_valid` and `done` are low, `in_ready` is high and all taps are zero.
- R9: From the cycle after a flush is accepted until `done`, `in_ready` is low and `in_valid` is ignored.
- R10: A flush pulse while the block is idle has no effect: no outputs are produced and `done` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Tap write strobe |
| cfg_addr | input | 4 | Tap index |
| cfg_re | input | 16 | Tap real part, signed |
| cfg_im | input | 16 | Tap imaginary part, signed |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_re | input | 16 | Sample real part, signed |
| in_im | input | 16 | Sample imaginary part, signed |
| flush | input | 1 | End the stream and drain the tail |
| out_valid | output | 1 | Output sample valid |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |
| done | output | 1 | One-cycle pulse after the last tail output |

## Verification
Each alignment chain in a sub-filter has a different length. A wrong offset, a wrong tap-to-group split, or a sub-filter line that steps on the wrong cycle therefore corrupts every output from the sample where the faulty group first contributes, and the error reaches the ports within three cycles of that sample's acceptance. Any state left over from a previous stream corrupts the first outputs of the next stream. A miscounted drain shows up as a wrong output count or a misplaced done pulse at the end of the stream.

// File: rtl/ola_fir_pkg.sv
package ola_fir_pkg;

  localparam int DW = 16;
  localparam int AW = 36;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [AW-1:0] re;
    logic signed [AW-1:0] im;
  } acc_t;

  function automatic logic signed [AW-1:0] sext(input logic signed [DW-1:0] v);
    return {{(AW-DW){v[DW-1]}}, v};
  endfunction

  // Four real multiplies per complex product.
  function automatic acc_t cmul(input cplx_t a, input cplx_t b);
    acc_t r;
    r.re = sext(a.re) * sext(b.re) - sext(a.im) * sext(b.im);
    r.im = sext(a.re) * sext(b.im) + sext(a.im) * sext(b.re);
    return r;
  endfunction

  function automatic acc_t cadd(input acc_t a, input acc_t b);
    acc_t r;
    r.re = a.re + b.re;
    r.im = a.im + b.im;
    return r;
  endfunction

  // Arithmetic right shift followed by clamping to the output range.
  function automatic logic signed [DW-1:0] sat_scale(input logic signed [AW-1:0] v,
                                                     input int unsigned sh);
    logic signed [AW-1:0] s;
    logic signed [AW-1:0] hi;
    logic signed [AW-1:0] lo;
    hi = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    lo = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    s  = v >>> sh;
    if (s > hi)      return hi[DW-1:0];
    else if (s < lo) return lo[DW-1:0];
    else             return s[DW-1:0];
  endfunction

endpackage

// File: rtl/ola_coef_bank.sv
module ola_coef_bank
  import ola_fir_pkg::*;
#(
  parameter int NCOEF = 16,
  localparam int AB = $clog2(NCOEF)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock,
  input  logic          we,
  input  logic [AB-1:0] addr,
  input  cplx_t         wdata,
  output cplx_t         h [NCOEF]
);

  cplx_t [NCOEF-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (we && !lock) begin
      mem[addr] <= wdata;
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_out
    assign h[k] = mem[k];
  end

  // R2: taps frozen while a stream holds the lock
  p_coef_hold_r2: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(mem));

endmodule

// File: rtl/ola_subfilter.sv
module ola_subfilter
  import ola_fir_pkg::*;
#(
  parameter int GLEN = 4,
  parameter int OFS  = 0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  step,
  input  cplx_t x,
  input  logic  adv,
  input  cplx_t h [GLEN],
  output acc_t  part
);

  cplx_t line  [GLEN];
  acc_t  chain [OFS+1];
  acc_t  prod_sum;

  // Private input history for this group of taps.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int j = 0; j < GLEN; j++) line[j] <= '0;
    end else if (step) begin
      line[0] <= x;
      for (int j = 1; j < GLEN; j++) line[j] <= line[j-1];
    end
  end

  // Short convolution against this group's taps.
  always_comb begin
    prod_sum = '0;
    for (int j = 0; j < GLEN; j++) prod_sum = cadd(prod_sum, cmul(line[j], h[j]));
  end

  // Offset alignment: partial delayed by OFS sample steps.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k <= OFS; k++) chain[k] <= '0;
    end else if (adv) begin
      chain[0] <= prod_sum;
      for (int k = 1; k <= OFS; k++) chain[k] <= chain[k-1];
    end
  end

  assign part = chain[OFS];

  // R6: history is empty after a clear
  p_clr_zero_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (part == '0));

endmodule

// File: rtl/ola_ctrl.sv
module ola_ctrl #(
  parameter int TAIL = 15,
  localparam int CNW = $clog2(TAIL + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic flush,
  output logic in_ready,
  output logic step,
  output logic inject,
  output logic s1_v,
  output logic s2_v,
  output logic clr,
  output logic lock,
  output logic done
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH, ST_DRAIN} st_t;

  st_t            st;
  logic [CNW-1:0] cnt;
  logic           acc;

  always_comb begin
    in_ready = (st == ST_IDLE) || (st == ST_RUN);
    acc      = in_valid && in_ready;
    inject   = (st == ST_FLUSH);
    step     = acc || inject;
    clr      = (st == ST_DRAIN) && !s1_v && !s2_v;
    lock     = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      done <= 1'b0;
    end else begin
      s1_v <= step;
      s2_v <= s1_v;
      done <= 1'b0;
      unique case (st)
        ST_IDLE:  if (in_valid) st <= ST_RUN;
        ST_RUN:   if (flush) begin
                    st  <= ST_FLUSH;
                    cnt <= '0;
                  end
        ST_FLUSH: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNW'(TAIL - 1)) st <= ST_DRAIN;
                  end
        ST_DRAIN: if (!s1_v && !s2_v) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                  end
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R5: zero injection never runs past the tail length
  p_flush_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLUSH) |-> (cnt < CNW'(TAIL)));

  // R9: input closed in the cycle before done
  p_ready_low_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!in_ready));

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/ola_fir.sv
module ola_fir
  import ola_fir_pkg::*;
#(
  parameter int NCOEF  = 16,
  parameter int NGRP   = 4,
  parameter int OSHIFT = 15,
  localparam int GLEN = NCOEF / NGRP,
  localparam int AB   = $clog2(NCOEF),
  localparam int TAIL = NCOEF - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [AB-1:0]        cfg_addr,
  input  logic signed [DW-1:0] cfg_re,
  input  logic signed [DW-1:0] cfg_im,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic                 flush,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 done
);

  logic  step, inject, s1_v, s2_v, clr, lock;
  cplx_t wcoef;
  cplx_t xin;
  cplx_t hbank [NCOEF];
  acc_t  part  [NGRP];
  acc_t  total;

  ola_ctrl #(.TAIL(TAIL)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .flush    (flush),
    .in_ready (in_ready),
    .step     (step),
    .inject   (inject),
    .s1_v     (s1_v),
    .s2_v     (s2_v),
    .clr      (clr),
    .lock     (lock),
    .done     (done)
  );

  always_comb begin
    wcoef.re = cfg_re;
    wcoef.im = cfg_im;
    if (inject) begin
      xin = '0;
    end else begin
      xin.re = in_re;
      xin.im = in_im;
    end
  end

  ola_coef_bank #(.NCOEF(NCOEF)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .lock  (lock),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (wcoef),
    .h     (hbank)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    cplx_t hg [GLEN];
    for (genvar j = 0; j < GLEN; j++) begin : g_tap
      assign hg[j] = hbank[g*GLEN + j];
    end
    ola_subfilter #(.GLEN(GLEN), .OFS(g*GLEN)) u_sf (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .step (step),
      .x    (xin),
      .adv  (s1_v),
      .h    (hg),
      .part (part[g])
    );
  end

  // Overlap-add of the aligned partials.
  always_comb begin
    total = '0;
    for (int g = 0; g < NGRP; g++) total = cadd(total, part[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) begin
        out_re <= sat_scale(total.re, OSHIFT);
        out_im <= sat_scale(total.im, OSHIFT);
      end
    end
  end

  // R4: fixed three-cycle acceptance-to-output latency
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> ##3 out_valid);

  // R6: done follows the final output directly
  p_done_after_out_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_valid) && !out_valid));

endmodule

// File: tb/ola_fir_tb.sv
module ola_fir_tb;

  localparam int NT   = 16;
  localparam int TAIL = NT - 1;
  localparam int NS   = 20;

  localparam logic signed [15:0] SRE [NS] = '{
    16'sd1200, -16'sd700, 16'sd1900, 16'sd35, -16'sd1500, 16'sd820, 16'sd0, -16'sd1999,
    16'sd640, 16'sd1111, -16'sd250, 16'sd1750, -16'sd930, 16'sd400, 16'sd1, -16'sd1205,
    16'sd1600, -16'sd45, 16'sd780, -16'sd1320};
  localparam logic signed [15:0] SIM [NS] = '{
    -16'sd300, 16'sd1450, 16'sd0, -16'sd1800, 16'sd990, 16'sd120, -16'sd640, 16'sd1500,
    16'sd75, -16'sd1100, 16'sd1999, -16'sd20, 16'sd560, -16'sd1700, 16'sd880, 16'sd430,
    -16'sd950, 16'sd1300, -16'sd1999, 16'sd215};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic signed [15:0] cfg_re = '0, cfg_im = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic flush = 1'b0;
  logic out_valid, done;
  logic signed [15:0] out_re, out_im;

  always #10 clk = ~clk;

  ola_fir u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_re(cfg_re),
    .cfg_im(cfg_im), .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re),
    .in_im(in_im), .flush(flush), .out_valid(out_valid), .out_re(out_re),
    .out_im(out_im), .done(done)
  );

  int tests = 0, errs = 0;
  int cyc = 0, ng = 0, ndone = 0, last_out_cyc = 0, done_cyc = 0;
  logic signed [15:0] got_re [64];
  logic signed [15:0] got_im [64];
  longint hr [NT], hi [NT];
  longint xr [64], xi [64];

  always @(negedge clk) begin
    cyc++;
    if (out_valid) begin
      if (ng < 64) begin
        got_re[ng] = out_re;
        got_im[ng] = out_im;
      end
      ng++;
      last_out_cyc = cyc;
    end
    if (done) begin
      ndone++;
      done_cyc = cyc;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    errs++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    summary();
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clamp_scale(input longint v);
    longint s;
    s = v >>> 15;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic load_taps(input int kind);
    for (int k = 0; k < NT; k++) begin
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_addr = 4'(k);
      if (kind == 0) begin
        cfg_re = 16'(((k * 37) % 11 - 5) * 500);
        cfg_im = 16'(((k * 53) % 7 - 3) * 700);
      end else begin
        cfg_re = 16'sd32767;
        cfg_im = 16'sd0;
      end
      hr[k] = longint'(cfg_re);
      hi[k] = longint'(cfg_im);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done();
    int w;
    w = 0;
    while (!done && w < 500) begin
      @(negedge clk);
      w++;
    end
  endtask

  // Feeds xr/xi[0..n-1], flushes, and checks every output against a direct-form sum.
  task automatic run_stream(input int n, input bit gap, input bit wr_mid,
                            input bit busy_in, input string tag);
    int base;
    int nout;
    longint ar, ai;
    base = ndone;
    ng = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re    = 16'(xr[i]);
      in_im    = 16'(xi[i]);
      cfg_we   = 1'b0;
      if (wr_mid && i == n / 2) begin
        cfg_we   = 1'b1;
        cfg_addr = 4'd0;
        cfg_re   = 16'sh1234;
        cfg_im   = -16'sd999;
      end
      if (gap) begin
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we   = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we   = 1'b0;
    flush    = 1'b1;
    @(negedge clk);
    flush    = 1'b0;
    in_valid = busy_in;
    in_re    = 16'sd7777;
    in_im    = -16'sd7777;
    chk(in_ready == 1'b0, "R9 in_ready during flush", longint'(in_ready), 0);
    wait_done();
    in_valid = 1'b0;
    @(negedge clk);
    nout = n + TAIL;
    chk(ng == nout, {"R5 output count ", tag}, ng, nout);
    chk(ndone - base == 1, "R6 done pulses", ndone - base, 1);
    chk(done_cyc == last_out_cyc + 1, "R6 done after last output", done_cyc, last_out_cyc + 1);
    for (int m = 0; m < nout && m < ng && m < 64; m++) begin
      ar = 0;
      ai = 0;
      for (int k = 0; k < NT; k++) begin
        if (m - k >= 0 && m - k < n) begin
          ar += xr[m-k] * hr[k] - xi[m-k] * hi[k];
          ai += xr[m-k] * hi[k] + xi[m-k] * hr[k];
        end
      end
      chk(longint'(got_re[m]) == clamp_scale(ar), {tag, " re"}, longint'(got_re[m]), clamp_scale(ar));
      chk(longint'(got_im[m]) == clamp_scale(ai), {tag, " im"}, longint'(got_im[m]), clamp_scale(ai));
    end
  endtask

  initial begin
    for (int k = 0; k < NT; k++) begin
      hr[k] = 0;
      hi[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(out_valid == 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);
    chk(done == 1'b0, "R8 done after reset", longint'(done), 0);
    chk(in_ready == 1'b1, "R8 in_ready after reset", longint'(in_ready), 1);

    // R8: taps reset to zero, so every output is zero
    for (int i = 0; i < 3; i++) begin
      xr[i] = longint'(SRE[i]);
      xi[i] = longint'(SIM[i]);
    end
    run_stream(3, 1'b0, 1'b0, 1'b0, "R8 zero taps");

    // R10: flush while idle does nothing
    ng = 0;
    begin
      int d0;
      d0 = ndone;
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      repeat (25) @(negedge clk);
      chk(ng == 0, "R10 idle flush outputs", ng, 0);
      chk(ndone == d0, "R10 idle flush done", ndone - d0, 0);
      chk(in_ready == 1'b1, "R10 idle flush ready", longint'(in_ready), 1);
    end

    // R1, R3: table walk with loaded taps, continuous input
    load_taps(0);
    for (int i = 0; i < NS; i++) begin
      xr[i] = longint'(SRE[i]);
      xi[i] = longint'(SIM[i]);
    end
    run_stream(NS, 1'b0, 1'b0, 1'b0, "R1 R3 table");

    // R4: gaps between samples, same result; R9 in_valid held high during flush
    run_stream(NS, 1'b1, 1'b0, 1'b1, "R4 R9 gapped");

    // R2: write attempted mid-stream is ignored, then the next stream uses old taps
    run_stream(NS, 1'b0, 1'b1, 1'b0, "R2 write during stream");
    run_stream(NS, 1'b0, 1'b0, 1'b0, "R2 R6 following stream");

    // R4: exact latency for a single sample
    ng = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_re = 16'sd1000;
    in_im = -16'sd500;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R4 latency cycle 1", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 latency cycle 2", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 latency cycle 3", longint'(out_valid), 1);
    chk(out_re == 16'(clamp_scale(1000 * hr[0] + 500 * hi[0])), "R4 R3 first value",
        longint'(out_re), clamp_scale(1000 * hr[0] + 500 * hi[0]));
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    wait_done();
    @(negedge clk);
    chk(ng == 1 + TAIL, "R5 single-sample count", ng, 1 + TAIL);

    // R7: saturation in both directions
    load_taps(1);
    for (int i = 0; i < NS; i++) begin
      xr[i] = (i < NS / 2) ? 32767 : -32768;
      xi[i] = (i % 3 == 0) ? 20000 : -20000;
    end
    run_stream(NS, 1'b0, 1'b0, 1'b0, "R7 saturation");

    summary();
  end

endmodule